// File: doc/BRIEF.md
# Two-Group Tick Rate Generator

This block turns one reference clock into five independent single-cycle tick enables for a bank of timer channels. Two shared 8-bit prescaler stages sit in front of the channels. The first stage feeds the two lowest channels and the second feeds the other three. Each channel then applies its own power-of-two divider, chosen by a 4-bit selector. The resulting tick period, in reference clocks, is (prescale value + 1) multiplied by 2 to the power of the selector.

A register block writes two configuration words through a write strobe and a one-bit word select. Every write, to either word, restarts all stage and divider counters together. All five channels therefore come back into a known phase under the new rates, and the first tick of each channel falls at a fixed distance from the write.

Top module: `tick_rate_gen`

## Requirements
- R1: With `cfg_sel` = 0 a write loads the prescale word: bits 7:0 are the group-0 prescale value and bits 15:8 the group-1 value (bits 19:16 are not used).
- R2: Channels 0 and 1 count group-0 stage pulses, and channels 2, 3 and 4 count group-1 stage pulses.
- R3: A stage with prescale value P emits one stage pulse every P+1 reference clocks.
- R4: With `cfg_sel` = 1 a write loads the selector word, where channel n's selector F sits in bits 4n+3:4n. Channel n then ticks once every (P+1)·2^F clocks, with P the value of its group.
- R5: Each tick is high for a single clock, unless the period is 1 clock (P=0, F=0), in which case it stays high. A tick only follows a stage pulse of the channel's group in the previous clock.
- R6: Synchronous reset sets the prescale word to 0x0101 and the selector word to 0 and holds all ticks low. The first tick of every channel comes 3 clocks after the last reset edge, and ticks then repeat every 2 clocks.
- R7: A write to either word clears all ticks on the following clock and restarts every counter. A channel with period T first ticks T+1 clocks after the write edge and every T clocks after that.
- R8: While `cfg_we` is low, changes on `cfg_data` and `cfg_sel` have no effect on any tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe, one clock per write |
| cfg_sel | input | 1 | Word select: 0 prescale word, 1 selector word |
| cfg_data | input | 20 | Configuration write data |
| tick_o | output | 5 | Registered tick enable, one bit per channel |

## Verification
The path has three registers: the stage counter, the stage pulse flop and the divider's tick flop. The first tick after a write or reset edge E is therefore due at the output after edge E+T+1, and later ticks follow every T edges. For each channel, the driver computes these due edges from the written fields and queues them. The monitor samples `tick_o` at the falling edge, with the edge count it keeps itself, and treats any tick off the queue or any due tick that does not appear as a failure. During the no-write window the selection and data inputs are toggled while the queued schedule is kept unchanged.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic {
    CFG_PRESCALE = 1'b0,
    CFG_DIVIDE   = 1'b1
  } cfg_word_e;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             stage_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q   <= '0;
      stage_o <= 1'b0;
    end else if (cnt_q == limit_i) begin
      cnt_q   <= '0;
      stage_o <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      stage_o <= 1'b0;
    end
  end

  // R3: back-to-back stage pulses only when the stage divides by one
  assert_stage_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (stage_o && !restart_i) |=> (!stage_o || $past(limit_i) == '0));
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int SEL_W = 4,
  localparam int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             stage_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wrap_at;

  // all-ones mask of width sel_i; the shift overflow covers the top value
  assign wrap_at = (CNT_W'(1) << sel_i) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (stage_i) begin
      if (cnt_q == wrap_at) begin
        cnt_q  <= '0;
        tick_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        tick_o <= 1'b0;
      end
    end else begin
      tick_o <= 1'b0;
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= wrap_at);

  assert_tick_follows_stage_R5: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(stage_i));
endmodule

// File: rtl/tick_rate_gen.sv
module tick_rate_gen #(
  parameter int NUM_CH  = 5,
  parameter int PRE_W   = 8,
  parameter int SEL_W   = 4,
  parameter int GRP0_CH = 2,
  localparam int NUM_GRP  = 2,
  localparam int PRE_BITS = NUM_GRP * PRE_W,
  localparam int SEL_BITS = NUM_CH * SEL_W,
  localparam int CFG_W    = (PRE_BITS > SEL_BITS) ? PRE_BITS : SEL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_data,
  output logic [NUM_CH-1:0] tick_o
);
  import tick_pkg::*;

  localparam logic [PRE_BITS-1:0] PRE_RST = {NUM_GRP{PRE_W'(1)}};

  logic [PRE_BITS-1:0] pre_cfg;
  logic [SEL_BITS-1:0] sel_cfg;
  logic [NUM_GRP-1:0]  stage;
  logic                restart;
  cfg_word_e           word;

  assign word    = cfg_word_e'(cfg_sel);
  assign restart = rst | cfg_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cfg <= PRE_RST;
      sel_cfg <= '0;
    end else if (cfg_we) begin
      if (word == CFG_PRESCALE) pre_cfg <= cfg_data[PRE_BITS-1:0];
      else                      sel_cfg <= cfg_data[SEL_BITS-1:0];
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_stage
    tick_prescaler #(.PRE_W(PRE_W)) i_stage (
      .clk       (clk),
      .rst       (rst),
      .restart_i (restart),
      .limit_i   (pre_cfg[g*PRE_W +: PRE_W]),
      .stage_o   (stage[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    localparam int GRP = (c < GRP0_CH) ? 0 : 1;

    tick_divider #(.SEL_W(SEL_W)) i_div (
      .clk       (clk),
      .rst       (rst),
      .restart_i (restart),
      .stage_i   (stage[GRP]),
      .sel_i     (sel_cfg[c*SEL_W +: SEL_W]),
      .tick_o    (tick_o[c])
    );

    assert_grp_source_R2: assert property (@(posedge clk) disable iff (rst)
      tick_o[c] |-> $past(stage[GRP]));
  end

  assert_reset_cfg_R6: assert property (@(posedge clk)
    rst |=> (pre_cfg == PRE_RST && sel_cfg == '0 && tick_o == '0));

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (tick_o == '0));

  assert_hold_cfg_R8: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(pre_cfg) && $stable(sel_cfg)));
endmodule

// File: tb/test_tick_rate_gen.sv
module test_tick_rate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [19:0] cfg_data = '0;
  logic [4:0]  tick;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int hz = -1;
  int mon_e;
  int exp_q[NCH][$];
  string req = "R6";
  bit done = 1'b0;

  tick_rate_gen i_tick_rate_gen (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .tick_o   (tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops the expected tick cycles and compares
  always @(negedge clk) begin
    if (cyc <= hz) begin
      for (int c = 0; c < NCH; c++) begin
        if (tick[c]) begin
          total++;
          if (exp_q[c].size() == 0) begin
            bad++;
            $display("FAIL %s ch%0d unexpected tick at cycle %0d: actual=1 expected=0", req, c, cyc);
          end else begin
            mon_e = exp_q[c].pop_front();
            if (mon_e != cyc) begin
              bad++;
              $display("FAIL %s ch%0d tick cycle: actual=%0d expected=%0d", req, c, cyc, mon_e);
            end
          end
        end else if (exp_q[c].size() > 0 && exp_q[c][0] == cyc) begin
          total++;
          bad++;
          $display("FAIL %s ch%0d missed tick at cycle %0d: actual=0 expected=1", req, c, cyc);
          void'(exp_q[c].pop_front());
        end
      end
    end
  end

  task automatic arm(input int e0, input int per[NCH], input int horizon);
    for (int c = 0; c < NCH; c++) begin
      exp_q[c].delete();
      for (int k = e0 + per[c] + 1; k <= e0 + horizon; k += per[c])
        exp_q[c].push_back(k);
    end
    hz = e0 + horizon;
  endtask

  task automatic write_cfg(input bit sel, input logic [19:0] d, output int e);
    @(negedge clk); #1;
    hz = -1;
    for (int c = 0; c < NCH; c++) exp_q[c].delete();
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk); #1;
    e = cyc;
    cfg_we = 1'b0;
  endtask

  task automatic run_window(input bit scramble);
    while (cyc < hz) begin
      @(negedge clk); #1;
      if (scramble) begin
        cfg_data = 20'(cyc * 7919);
        cfg_sel  = cyc[0];
      end
    end
    @(negedge clk); #1;
  endtask

  initial begin
    int e;
    // R6: ticks stay low while reset is held
    repeat (3) begin
      @(negedge clk);
      total++;
      if (tick !== 5'b0) begin
        bad++;
        $display("FAIL R6 tick during reset: actual=%b expected=00000", tick);
      end
    end
    #1; rst = 1'b0;
    req = "R6";
    arm(cyc, '{2, 2, 2, 2, 2}, 40);
    run_window(1'b0);

    // R1 R2 R3 R4: distinct group values and selectors 0, 1, 4
    req = "R1/R2/R3/R4";
    write_cfg(1'b0, 20'h00502, e);
    write_cfg(1'b1, 20'h10410, e);
    arm(e, '{3, 6, 96, 6, 12}, 250);
    run_window(1'b0);

    // R5 and R8: unit stage, continuous tick on period 1, inputs toggled without strobe
    req = "R5/R8";
    write_cfg(1'b0, 20'h00000, e);
    write_cfg(1'b1, 20'h04104, e);
    arm(e, '{16, 1, 2, 16, 1}, 100);
    run_window(1'b1);
    cfg_data = '0; cfg_sel = 1'b0;

    // R3 R4: largest prescale value on group 0
    req = "R3/R4";
    write_cfg(1'b0, 20'h001FF, e);
    write_cfg(1'b1, 20'h00001, e);
    arm(e, '{512, 256, 2, 2, 2}, 1100);
    run_window(1'b0);

    // R7: selector-only write restarts every channel
    req = "R7";
    write_cfg(1'b1, 20'h00000, e);
    arm(e, '{256, 256, 2, 2, 2}, 600);
    run_window(1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule